// File: doc/BRIEF.md
# Reset Source Combiner with Cause Status

This block merges every reset origin of a small controller into one held core reset. It takes four sources. The first is a synchronous power-on strobe. The second is a low-supply comparison against a level picked by a two-bit configuration field. The third is an active-low external reset pin. The fourth is a watchdog overflow that only counts when the watchdog is enabled. Once every source has gone quiet, the core reset is still held for a fixed number of slow ticks, so clocks and supply can settle.

The block also keeps two sticky status flags, `to_o` and `pd_o`. Firmware reads them after a restart to learn why the core was reset. Reset events change them, and so do the clear-watchdog and sleep strobes that the core issues while it runs. The four combinations of (`to_o`, `pd_o`) mean:

- 0,0: watchdog wake from sleep
- 0,1: watchdog overflow while awake
- 1,0: external reset during sleep
- 1,1: power-up, low supply, or external reset while awake

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `por_i` is high, the next clock edge sets `core_rst_o`=1, `to_o`=1 and `pd_o`=1.
- R2: The external pin and the low-supply result each pass through a two-flop synchronizer. A low on `ext_rst_n_i` sampled at edge n raises `core_rst_o` at edge n+2 and not earlier.
- R3: `core_rst_o` falls on the HOLD_TICKS-th ticked edge after the synchronized sources all read inactive. Any source seen again before that restarts the count from zero.
- R4: Only edges with `tick_i`=1 advance the hold count. With `tick_i`=0 the reset is never released.
- R5: `lvd_sel_i` picks the trip level in 0.1 V units of `supply_lvl_i`: 00 gives 40, 01 gives 20, 10 gives 10. A supply strictly below the level is a reset source. Code 11 disables the detector. A low-supply reset sets `to_o`=1 and `pd_o`=1.
- R6: With `wdt_en_i`=1, a `wdt_ovf_i` pulse sampled at edge n raises `core_rst_o` and clears `to_o` at edge n+1, and leaves `pd_o` unchanged. With `wdt_en_i`=0 the overflow has no effect.
- R7: A `sleep_i` strobe while the core runs sets `to_o`=1 and `pd_o`=0 at the next edge.
- R8: A `clrwdt_i` strobe while the core runs sets `to_o`=1 and `pd_o`=1 at the next edge.
- R9: An external reset leaves `to_o` and `pd_o` unchanged. While `core_rst_o` is high, the sleep and clear-watchdog strobes are ignored.
- R10: If events coincide on one edge, the priority is: watchdog reset event, then sleep, then clear-watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow free-running clock |
| por_i | input | 1 | Power-on strobe, active high, synchronous |
| tick_i | input | 1 | Hold-count enable tick |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| supply_lvl_i | input | SUP_W | Digitized supply level, 0.1 V per LSB |
| lvd_sel_i | input | 2 | Low-supply trip level select |
| wdt_en_i | input | 1 | Watchdog enable |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| clrwdt_i | input | 1 | Clear-watchdog strobe from the core |
| sleep_i | input | 1 | Sleep-entry strobe from the core |
| core_rst_o | output | 1 | Held core reset, active high |
| to_o | output | 1 | Time-out status flag |
| pd_o | output | 1 | Power-down status flag |

## Verification
Latencies differ by source:

- Pin and supply events cross two synchronizer flops and then the reset register, so they are checked three edges after being driven and also confirmed absent one edge earlier.
- A watchdog overflow passes through one event register, so its reset and its `to_o` clear are checked on the second edge.
- Strobes are checked on the first edge.
- The release is checked both one ticked edge before the computed release edge, where it must still be high, and on that edge, where it must be low.

All sampling happens one nanosecond after the rising edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        LVL_HIGH = 2'b00,
        LVL_MID  = 2'b01,
        LVL_LOW  = 2'b10,
        LVL_OFF  = 2'b11
    } lvd_level_e;

    typedef struct packed {
        logic to;
        logic pd;
    } cause_t;

    localparam cause_t CAUSE_COLD = '{to: 1'b1, pd: 1'b1};

    localparam int THR_HIGH = 40;
    localparam int THR_MID  = 20;
    localparam int THR_LOW  = 10;

    function automatic int unsigned level_threshold(lvd_level_e sel);
        case (sel)
            LVL_HIGH: return THR_HIGH;
            LVL_MID:  return THR_MID;
            LVL_LOW:  return THR_LOW;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= RST_VAL;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rstc_lvd_cmp.sv
module rstc_lvd_cmp
    import rstc_pkg::*;
#(
    parameter int SUP_W = 6
) (
    input  logic [SUP_W-1:0] supply_i,
    input  logic [1:0]       sel_i,
    output logic             trip_o
);
    lvd_level_e       sel;
    logic [SUP_W-1:0] thr;

    always_comb begin
        sel    = lvd_level_e'(sel_i);
        thr    = SUP_W'(level_threshold(sel));
        trip_o = (sel != LVL_OFF) && (supply_i < thr);
    end

    // R5: the reserved code never trips
    always_comb begin
        if (sel_i == 2'b11) assert (!trip_o) else $error("p_off_code_r5");
    end
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
    parameter int HOLD_TICKS = 20
) (
    input  logic clk,
    input  logic por_i,
    input  logic src_any_i,
    input  logic tick_i,
    output logic rst_o
);
    localparam int CNT_W = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS);

    logic [CNT_W-1:0] cnt;
    logic             rst_q;

    always_ff @(posedge clk) begin
        if (por_i || src_any_i) begin
            cnt   <= '0;
            rst_q <= 1'b1;
        end else if (rst_q && tick_i) begin
            if (cnt == CNT_W'(HOLD_TICKS - 1)) begin
                rst_q <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rst_o = rst_q;

    p_src_holds_r3: assert property (@(posedge clk) disable iff (por_i)
        src_any_i |=> rst_q);

    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (por_i)
        $fell(rst_q) |-> ($past(tick_i) && !$past(src_any_i)));
endmodule

// File: rtl/rstc_status.sv
module rstc_status
    import rstc_pkg::*;
(
    input  logic clk,
    input  logic por_i,
    input  logic lvd_i,
    input  logic wdt_evt_i,
    input  logic core_rst_i,
    input  logic sleep_i,
    input  logic clrwdt_i,
    output logic to_o,
    output logic pd_o
);
    cause_t st;
    logic   run;

    assign run = !core_rst_i;

    always_ff @(posedge clk) begin
        if (por_i || lvd_i) begin
            st <= CAUSE_COLD;
        end else if (wdt_evt_i) begin
            st.to <= 1'b0;
        end else if (run && sleep_i) begin
            st <= '{to: 1'b1, pd: 1'b0};
        end else if (run && clrwdt_i) begin
            st <= CAUSE_COLD;
        end
    end

    assign to_o = st.to;
    assign pd_o = st.pd;

    p_por_cold_r1: assert property (@(posedge clk)
        por_i |=> (st.to && st.pd));

    p_wdt_clears_to_r6: assert property (@(posedge clk) disable iff (por_i)
        (wdt_evt_i && !lvd_i) |=> (!st.to && $stable(st.pd)));

    p_sleep_pd_r7: assert property (@(posedge clk) disable iff (por_i)
        (run && sleep_i && !wdt_evt_i && !lvd_i) |=> (st.to && !st.pd));

    p_clrwdt_r8: assert property (@(posedge clk) disable iff (por_i)
        (run && clrwdt_i && !sleep_i && !wdt_evt_i && !lvd_i) |=> (st.to && st.pd));

    p_ignored_in_reset_r9: assert property (@(posedge clk) disable iff (por_i)
        (core_rst_i && !wdt_evt_i && !lvd_i) |=> $stable(st));
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
    import rstc_pkg::*;
#(
    parameter int SUP_W      = 6,
    parameter int HOLD_TICKS = 20,
    parameter int SYNC_STG   = 2
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             tick_i,
    input  logic             ext_rst_n_i,
    input  logic [SUP_W-1:0] supply_lvl_i,
    input  logic [1:0]       lvd_sel_i,
    input  logic             wdt_en_i,
    input  logic             wdt_ovf_i,
    input  logic             clrwdt_i,
    input  logic             sleep_i,
    output logic             core_rst_o,
    output logic             to_o,
    output logic             pd_o
);
    localparam logic [1:0] SYNC_RST = 2'b10;

    logic       lvd_raw;
    logic [1:0] sync_q;
    logic       lvd_s;
    logic       ext_n_s;
    logic       wdt_evt_q;
    logic       src_any;
    logic       rst_int;

    rstc_lvd_cmp #(.SUP_W(SUP_W)) u_cmp (
        .supply_i (supply_lvl_i),
        .sel_i    (lvd_sel_i),
        .trip_o   (lvd_raw)
    );

    rstc_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (por_i),
        .d_i ({lvd_raw, ext_rst_n_i}),
        .q_o (sync_q)
    );

    assign lvd_s   = sync_q[1];
    assign ext_n_s = sync_q[0];

    always_ff @(posedge clk) begin
        if (por_i) wdt_evt_q <= 1'b0;
        else       wdt_evt_q <= wdt_ovf_i && wdt_en_i && !rst_int;
    end

    assign src_any = lvd_s || !ext_n_s || wdt_evt_q;

    rstc_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .por_i     (por_i),
        .src_any_i (src_any),
        .tick_i    (tick_i),
        .rst_o     (rst_int)
    );

    rstc_status u_stat (
        .clk        (clk),
        .por_i      (por_i),
        .lvd_i      (lvd_s),
        .wdt_evt_i  (wdt_evt_q),
        .core_rst_i (rst_int),
        .sleep_i    (sleep_i),
        .clrwdt_i   (clrwdt_i),
        .to_o       (to_o),
        .pd_o       (pd_o)
    );

    assign core_rst_o = rst_int;

    p_por_holds_r1: assert property (@(posedge clk)
        por_i |=> core_rst_o);

    p_ext_pin_r2: assert property (@(posedge clk) disable iff (por_i)
        !ext_n_s |=> core_rst_o);

    p_wdt_reset_r6: assert property (@(posedge clk) disable iff (por_i)
        wdt_evt_q |=> core_rst_o);

    p_wdt_disabled_r6: assert property (@(posedge clk) disable iff (por_i)
        !wdt_en_i |=> !wdt_evt_q);
endmodule

// File: tb/tb_reset_cause_ctrl.sv
module tb_reset_cause_ctrl;
    localparam int SUP_W = 6;
    localparam int HOLD  = 20;
    localparam int NVEC  = 9;

    // {sel[1:0], supply[5:0], expect_trip}
    localparam logic [8:0] VEC [NVEC] = '{
        {2'b00, 6'd39, 1'b1}, {2'b00, 6'd40, 1'b0},
        {2'b01, 6'd19, 1'b1}, {2'b01, 6'd20, 1'b0},
        {2'b10, 6'd9,  1'b1}, {2'b10, 6'd10, 1'b0},
        {2'b11, 6'd0,  1'b0}, {2'b00, 6'd25, 1'b1},
        {2'b01, 6'd25, 1'b0}
    };

    logic clk = 1'b0;
    logic por = 1'b1, tick = 1'b1, ext_n = 1'b1;
    logic [SUP_W-1:0] supply = 6'd63;
    logic [1:0] sel = 2'b00;
    logic wdt_en = 1'b0, wdt_ovf = 1'b0, clrwdt = 1'b0, sleep = 1'b0;
    logic core_rst, to_f, pd_f;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    reset_cause_ctrl #(.SUP_W(SUP_W), .HOLD_TICKS(HOLD)) dut (
        .clk          (clk),
        .por_i        (por),
        .tick_i       (tick),
        .ext_rst_n_i  (ext_n),
        .supply_lvl_i (supply),
        .lvd_sel_i    (sel),
        .wdt_en_i     (wdt_en),
        .wdt_ovf_i    (wdt_ovf),
        .clrwdt_i     (clrwdt),
        .sleep_i      (sleep),
        .core_rst_o   (core_rst),
        .to_o         (to_f),
        .pd_o         (pd_f)
    );

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [2:0] exp);
        checks++;
        if ({core_rst, to_f, pd_f} !== exp) begin
            errors++;
            $display("FAIL %s rst/to/pd actual %b expected %b", req, {core_rst, to_f, pd_f}, exp);
        end
    endtask

    task automatic pulse_sleep();
        sleep = 1'b1; step(1); sleep = 1'b0;
    endtask

    task automatic pulse_clrwdt();
        clrwdt = 1'b1; step(1); clrwdt = 1'b0;
    endtask

    initial begin
        step(2);
        chk("R1", 3'b111);
        por = 1'b0;
        step(1 + HOLD); chk("R3", 3'b111);
        step(1);        chk("R3", 3'b011);

        // R5 level table
        for (int i = 0; i < NVEC; i++) begin
            sel    = VEC[i][8:7];
            supply = VEC[i][6:1];
            step(3);
            chk("R5", {VEC[i][0], 2'b11});
            supply = 6'd63;
            step(HOLD + 4);
        end
        sel = 2'b00;

        pulse_sleep();  chk("R7", 3'b010);
        supply = 6'd5; step(3); chk("R5", 3'b111);
        supply = 6'd63; step(HOLD + 4); chk("R5", 3'b011);

        pulse_sleep();
        pulse_clrwdt(); chk("R8", 3'b011);

        // external reset during sleep
        pulse_sleep();
        ext_n = 1'b0; step(2); chk("R2", 3'b010);
        step(1);               chk("R2", 3'b110);
        pulse_clrwdt();        chk("R9", 3'b110);
        pulse_sleep();         chk("R9", 3'b110);
        ext_n = 1'b1; step(HOLD); chk("R3", 3'b110);
        ext_n = 1'b0; step(1);
        ext_n = 1'b1; step(1 + HOLD); chk("R3", 3'b110);
        step(1);                      chk("R3", 3'b010);

        // watchdog while awake
        pulse_clrwdt();
        wdt_en = 1'b1; wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
        chk("R6", 3'b011);
        step(1);        chk("R6", 3'b101);
        step(HOLD - 1); chk("R3", 3'b101);
        step(1);        chk("R3", 3'b001);

        wdt_en = 1'b0; wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
        step(3); chk("R6", 3'b001);

        // watchdog wake from sleep
        wdt_en = 1'b1;
        pulse_sleep();
        wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
        step(1); chk("R6", 3'b100);
        step(HOLD + 1); chk("R6", 3'b000);

        // R10 priority
        pulse_clrwdt();
        wdt_ovf = 1'b1; step(1); wdt_ovf = 1'b0;
        sleep = 1'b1; clrwdt = 1'b1; step(1); sleep = 1'b0; clrwdt = 1'b0;
        chk("R10", 3'b101);
        step(HOLD + 1);
        sleep = 1'b1; clrwdt = 1'b1; step(1); sleep = 1'b0; clrwdt = 1'b0;
        chk("R10", 3'b010);

        // R4 tick gating
        tick = 1'b0;
        ext_n = 1'b0; step(3); chk("R4", 3'b110);
        ext_n = 1'b1; step(HOLD + 10); chk("R4", 3'b110);
        tick = 1'b1; step(HOLD - 1); chk("R4", 3'b110);
        step(1); chk("R4", 3'b010);

        por = 1'b1; step(1); chk("R1", 3'b111);
        por = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule